// File: doc/BRIEF.md
# Programmable Twisted-Ring Clock Divider

This block is a five-stage twisted-ring (Johnson) counter. It divides its clock by any whole ratio from 2 to 10. A 4-bit select picks the feedback that drives the first stage:

- **Even ratios** feed back the inverted output of a single stage.
- **Odd ratios** feed back the NAND of two adjacent stages. This removes the all-zero code from the cycle, so the cycle is one state shorter.
- **Select value 0** takes the first stage's input from an external serial pin instead. The ring then acts as a plain five-bit shift register, and the external logic can build longer dividers.

All five stage values are outputs. A divided clock is taken from the last stage that the selected ratio uses.

The block also has a synchronous clear and a per-stage parallel load. An anti-lock guard watches the active stages. If they ever hold a pattern that is not a legal twisted-ring code, the guard sends the whole ring back to zero on the next edge. The block has no data stream; every pin is a plain control or status level and there is no valid/ready handshake.

Top module: `jdiv_counter`

## Requirements
- R1: On a rising edge with `rst` high, all five stages become 0, whatever `preset_en` and `jam` are.
- R2: On a rising edge with `rst` low and `preset_en` high, `stage_q` takes `jam`: bit 0 is stage 1 and bit 4 is stage 5.
- R3: On a counting edge (`rst` and `preset_en` low, state legal), the stages shift: `stage_q[i]` takes `stage_q[i-1]` and `stage_q[0]` takes the feedback bit.
- R4: For an even select M, the active length L is M/2 and the feedback is the inverse of `stage_q[L-1]`. From all-zero, after n counts (0 < n < M) the active bits equal (1<<n)-1 for n ≤ L, and mask & ~((1<<(n-L))-1) for n > L.
- R5: For an odd select M, L is (M+1)/2 and the feedback is NAND(`stage_q[L-2]`, `stage_q[L-1]`). The active bits follow the same formula as R4 for 0 < n < M, and the cycle length is M.
- R6: With select 0, `stage_q[0]` takes `ext_data` on each counting edge and no pattern is corrected.
- R7: Select values 1 and 11 to 15 behave exactly like select 10.
- R8: In any internal mode, if the active stages (stages 1..L) contain more than one change between neighbouring bits, the next counting edge clears all five stages to 0.
- R9: `div_out` equals `stage_q[L-1]`, where L is 5 for select 0. In internal modes it is periodic with period M and is high for L of every M clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, rising edge active |
| rst | input | 1 | Synchronous clear, active high, highest priority |
| preset_en | input | 1 | Synchronous parallel load of `jam` |
| jam | input | 5 | Per-stage load values, bit 0 = stage 1 |
| ext_data | input | 1 | Serial input used when the select is 0 |
| ratio_sel | input | 4 | Division ratio: 0 = external, 2..10 internal |
| stage_q | output | 5 | Stage values, bit 0 = stage 1 |
| div_out | output | 1 | Divided clock, last active stage |

## Verification
The bound checker checks on every edge:
- clear priority,
- the parallel load,
- the shift relation between neighbouring stages,
- the feedback rules for the ratios 10 and 9,
- external-input shifting.

The bench scenarios cover what a one-cycle property cannot show:
- the full counting sequence and the period and duty of `div_out` for every ratio,
- the fallback of unsupported selects,
- anti-lock recovery from loaded illegal patterns under several lengths,
- legal loaded states being kept.

// File: rtl/jdiv_pkg.sv
package jdiv_pkg;
  localparam int STAGES = 5;
  localparam int SEL_W  = 4;
  localparam int LEN_W  = $clog2(STAGES + 1);

  typedef struct packed {
    logic             ext;
    logic             odd;
    logic [LEN_W-1:0] len;
  } ring_cfg_t;

  function automatic ring_cfg_t decode_ratio(input logic [SEL_W-1:0] sel);
    ring_cfg_t c;
    int        s;
    s     = int'(sel);
    c.ext = 1'b0;
    c.odd = 1'b0;
    c.len = LEN_W'(STAGES);
    if (s == 0) begin
      c.ext = 1'b1;
    end else if (s >= 2 && s <= 2 * STAGES) begin
      c.odd = sel[0];
      c.len = LEN_W'((s + 1) / 2);
    end
    return c;
  endfunction
endpackage

// File: rtl/jdiv_feedback.sv
module jdiv_feedback
  import jdiv_pkg::*;
#(
  parameter int N = STAGES
) (
  input  logic [N-1:0] q,
  input  ring_cfg_t    cfg,
  input  logic         ext_data,
  output logic         d
);
  logic top_bit, pre_bit;

  always_comb begin
    top_bit = 1'b0;
    pre_bit = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (i == int'(cfg.len) - 1) top_bit = q[i];
      if (i == int'(cfg.len) - 2) pre_bit = q[i];
    end
    if (cfg.ext)      d = ext_data;
    else if (cfg.odd) d = ~(pre_bit & top_bit);
    else              d = ~top_bit;
  end
endmodule

// File: rtl/jdiv_lockguard.sv
module jdiv_lockguard
  import jdiv_pkg::*;
#(
  parameter int N = STAGES
) (
  input  logic [N-1:0] q,
  input  ring_cfg_t    cfg,
  output logic         illegal
);
  localparam int CNT_W = $clog2(N);
  logic [N-2:0] edge_hit;

  genvar g;
  generate
    for (g = 0; g < N - 1; g++) begin : g_edge
      assign edge_hit[g] = (q[g] ^ q[g+1]) && (g + 1 < int'(cfg.len));
    end
  endgenerate

  logic [CNT_W-1:0] n_edges;
  always_comb begin
    n_edges = '0;
    for (int i = 0; i < N - 1; i++) n_edges = n_edges + CNT_W'(edge_hit[i]);
    illegal = !cfg.ext && (n_edges > CNT_W'(1));
  end
endmodule

// File: rtl/jdiv_ring.sv
module jdiv_ring #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [N-1:0] jam,
  input  logic         clear,
  input  logic         d,
  output logic [N-1:0] q
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_stage
      logic shift_in;
      if (g == 0) begin : g_head
        assign shift_in = d;
      end else begin : g_body
        assign shift_in = q[g-1];
      end
      always_ff @(posedge clk) begin
        if (rst)        q[g] <= 1'b0;
        else if (load)  q[g] <= jam[g];
        else if (clear) q[g] <= 1'b0;
        else            q[g] <= shift_in;
      end
    end
  endgenerate
endmodule

// File: rtl/jdiv_counter.sv
module jdiv_counter
  import jdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              preset_en,
  input  logic [STAGES-1:0] jam,
  input  logic              ext_data,
  input  logic [SEL_W-1:0]  ratio_sel,
  output logic [STAGES-1:0] stage_q,
  output logic              div_out
);
  ring_cfg_t cfg;
  logic      fb_bit;
  logic      bad_state;

  assign cfg = decode_ratio(ratio_sel);

  jdiv_feedback #(.N(STAGES)) u_fb (
    .q(stage_q), .cfg(cfg), .ext_data(ext_data), .d(fb_bit)
  );

  jdiv_lockguard #(.N(STAGES)) u_guard (
    .q(stage_q), .cfg(cfg), .illegal(bad_state)
  );

  jdiv_ring #(.N(STAGES)) u_ring (
    .clk(clk), .rst(rst), .load(preset_en), .jam(jam),
    .clear(bad_state), .d(fb_bit), .q(stage_q)
  );

  always_comb begin
    div_out = 1'b0;
    for (int i = 0; i < STAGES; i++)
      if (i == int'(cfg.len) - 1) div_out = stage_q[i];
  end
endmodule

// File: rtl/jdiv_counter_chk.sv
module jdiv_counter_chk
  import jdiv_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              preset_en,
  input logic [STAGES-1:0] jam,
  input logic              ext_data,
  input logic [SEL_W-1:0]  ratio_sel,
  input logic [STAGES-1:0] stage_q,
  input logic              div_out
);
  logic counting;
  assign counting = !rst && !preset_en;

  // R1
  clear_wins_chk: assert property (@(posedge clk) rst |=> stage_q == '0);

  // R2
  load_jam_chk: assert property (@(posedge clk) disable iff (rst)
    preset_en |=> stage_q == $past(jam));

  // R3
  shift_or_zero_chk: assert property (@(posedge clk) disable iff (rst)
    counting |=> (stage_q == '0) || (stage_q[STAGES-1:1] == $past(stage_q[STAGES-2:0])));

  // R4
  even_tap_chk: assert property (@(posedge clk) disable iff (rst)
    (counting && ratio_sel == 4'd10) |=> (stage_q == '0) || (stage_q[0] == !$past(stage_q[4])));

  // R5
  odd_nand_chk: assert property (@(posedge clk) disable iff (rst)
    (counting && ratio_sel == 4'd9) |=> (stage_q == '0) || (stage_q[0] == !($past(stage_q[3]) && $past(stage_q[4]))));

  // R6
  ext_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (counting && ratio_sel == 4'd0) |=> stage_q == {$past(stage_q[STAGES-2:0]), $past(ext_data)});
endmodule

bind jdiv_counter jdiv_counter_chk u_chk (.*);

// File: tb/jdiv_counter_tb.sv
module jdiv_counter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       preset_en = 1'b0;
  logic [4:0] jam = '0;
  logic       ext_data = 1'b0;
  logic [3:0] ratio_sel = 4'd10;
  logic [4:0] stage_q;
  logic       div_out;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  jdiv_counter u_dut (
    .clk(clk), .rst(rst), .preset_en(preset_en), .jam(jam),
    .ext_data(ext_data), .ratio_sel(ratio_sel), .stage_q(stage_q), .div_out(div_out)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R1 reset state", 32'(stage_q), 32'd0);

    // R4 R5 R7 R9: sweep every ratio plus one unsupported select
    for (int m = 2; m <= 11; m++) begin
      int ratio = (m == 11) ? 10 : m;
      int len = (ratio + 1) / 2;
      int mask = (1 << len) - 1;
      string tag;
      int highs;
      logic [15:0] rec;
      ratio_sel = (m == 11) ? 4'd13 : 4'(m);
      tag = (m == 11) ? "R7" : ((ratio % 2 == 0) ? "R4" : "R5");
      rst = 1'b1; tick(); rst = 1'b0;
      for (int n = 1; n < ratio; n++) begin
        int exp;
        tick();
        exp = (n <= len) ? ((1 << n) - 1) : (mask & ~((1 << (n - len)) - 1));
        chk(tag, 32'(stage_q) & 32'(mask), 32'(exp));
      end
      repeat (2 * ratio) tick();
      highs = 0;
      rec = '0;
      for (int n = 0; n < ratio; n++) begin
        rec[n] = div_out;
        highs += int'(div_out);
        tick();
      end
      chk("R9 duty", 32'(highs), 32'(len));
      for (int n = 0; n < ratio; n++) begin
        chk("R9 period", 32'(div_out), 32'(rec[n]));
        tick();
      end
    end

    // R2, R3: load a legal code and count on from it
    ratio_sel = 4'd10;
    preset_en = 1'b1; jam = 5'b00111; tick();
    chk("R2 load", 32'(stage_q), 32'h07);
    preset_en = 1'b0; tick();
    chk("R3 shift after load", 32'(stage_q), 32'h0F);

    // R1: clear beats load
    rst = 1'b1; preset_en = 1'b1; jam = 5'b11111; tick();
    chk("R1 priority over load", 32'(stage_q), 32'd0);
    rst = 1'b0;

    // R8: illegal pattern under length 5
    jam = 5'b00101; tick();
    chk("R2 load illegal", 32'(stage_q), 32'h05);
    preset_en = 1'b0; tick();
    chk("R8 len5 recovery", 32'(stage_q), 32'd0);

    // R8: illegal pattern under length 3
    ratio_sel = 4'd6; preset_en = 1'b1; jam = 5'b00101; tick();
    preset_en = 1'b0; tick();
    chk("R8 len3 recovery", 32'(stage_q), 32'd0);

    // R8 R3: outer stages ignored under length 2, legal state kept
    ratio_sel = 4'd4; preset_en = 1'b1; jam = 5'b10110; tick();
    preset_en = 1'b0; tick();
    chk("R8 legal kept", 32'(stage_q), 32'h0C);

    // R6: external serial input
    ratio_sel = 4'd0; rst = 1'b1; tick(); rst = 1'b0;
    begin
      logic [4:0] pat;
      pat = 5'b10110;
      for (int i = 4; i >= 0; i--) begin
        ext_data = pat[i];
        tick();
      end
      chk("R6 serial fill", 32'(stage_q), 32'(pat));
      chk("R9 ext div_out", 32'(div_out), 32'(pat[4]));
    end
    ext_data = 1'b0; preset_en = 1'b1; jam = 5'b00101; tick();
    preset_en = 1'b0; tick();
    chk("R6 no correction", 32'(stage_q), 32'h0A);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule